// File: doc/BRIEF.md
# Erase Status Polling Bit Generator

This block produces the byte a host reads back while a flash-style memory is erasing a set of blocks, while that erase is suspended, and while a program runs inside the suspension. The command decoder outside the block supplies the controller state as a small code, a flag telling whether the currently addressed block belongs to the erase set, the error flag, and the array data for the addressed location. A one-cycle read strobe marks each completed host read. From these the block forms either a status byte or passes the array data through.

Two toggle bits flip once per completed read while their condition holds, so a host polling twice can tell whether work is still in progress. An erase-timer bit shows whether the window for adding more blocks is still open. When the controller enters suspension, the block keeps showing erase status for a fixed number of clock cycles, `SUSP_LAT`, before it settles. This models the delay between the suspend request and the moment toggling stops. After that it shows the suspended view and raises `susp_settled`, which tells the surrounding logic that reads of unaffected blocks are back in read-array mode.

Status byte layout (all views): bit 7 done flag, bit 6 primary toggle, bit 5 error, bit 3 erase timer, bit 2 secondary toggle; bits 4, 1 and 0 read 0. Controller state codes: 0 read array, 1 erase timeout open, 2 erasing, 3 suspended, 4 program in suspend; codes 5 to 7 act as read array.

Top module: `erase_poll_status`

## Requirements
- R1: After reset both toggle bits hold 0 and `susp_settled` is 0, so the first status read after reset shows bit 6 = 0 and bit 2 = 0.
- R2: In read-array state (code 0, or codes 5 to 7), `rd_data` equals `array_data`, and read strobes do not change either toggle bit.
- R3: Bit 3 reads 0 in the timeout state (code 1) and 1 in the erasing state (code 2).
- R4: In the timeout, erasing and program-in-suspend states, bit 7 reads 0, bit 5 equals `err_in`, and bits 4, 1 and 0 read 0.
- R5: In the timeout and erasing states, bit 6 flips exactly once per cycle in which `rd_strobe` is high, and holds its value in cycles without a strobe, however many there are.
- R6: In the timeout and erasing states, bit 2 flips on a read strobe only when `blk_in_erase` is 1; otherwise it holds its value.
- R7: On entering the suspended state (code 3), the block shows the erasing view (bit 3 = 1, toggling as in R5 and R6) for exactly `SUSP_LAT` clock cycles and then raises `susp_settled`. `SUSP_LAT` lies between 25 and 3750 cycles, which at 250 MHz is the 0.1 us to 15 us window. The count restarts only when the state leaves both suspension codes.
- R8: In settled suspension with `blk_in_erase` = 1, the read returns bit 6 = 1, bit 2 = secondary toggle, and all other bits 0 (value 0x40 or 0x44). Bit 2 flips on each read strobe, and the stored primary toggle is left unchanged.
- R9: In settled suspension with `blk_in_erase` = 0, `rd_data` equals `array_data` and read strobes change neither toggle bit.
- R10: In program-in-suspend (code 4), the status byte is returned for every block, with bit 3 = 0, and both bit 6 and bit 2 flip on each read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_state | input | 3 | Controller state code |
| blk_in_erase | input | 1 | Addressed block belongs to the erase set |
| rd_strobe | input | 1 | One-cycle pulse marking a completed host read |
| err_in | input | 1 | Error flag reported in bit 5 |
| array_data | input | DATA_W | Array contents at the addressed location |
| rd_data | output | DATA_W | Byte presented to the host |
| susp_settled | output | 1 | Suspend latency has elapsed |

## Verification
The hardest case to reach from the ports is the drain window just after suspension begins, and how it combines with program-in-suspend. In that window the byte must still look like active erase, and reads made there must still flip both toggles. A later move to program-in-suspend must not restart the count. Directed steps measure the settle latency edge by edge and read inside the drain window. Constrained-random phases then hop between suspended and program-in-suspend codes with long idle stretches, so that settling happens at many points in relation to reads and state changes.

// File: rtl/erase_poll_pkg.sv
// Shared encodings for the erase status polling block.
// Assumes the controller state arrives as a 3-bit code from the decoder.
package erase_poll_pkg;
    typedef enum logic [2:0] {
        CS_READ     = 3'd0,
        CS_TIMEOUT  = 3'd1,
        CS_ERASE    = 3'd2,
        CS_SUSPEND  = 3'd3,
        CS_PGM_SUSP = 3'd4
    } ctrl_state_e;

    localparam int STAT_W    = 8;
    localparam int LANE_PRI  = 0;   // toggle lane shown on bit 6
    localparam int LANE_SEC  = 1;   // toggle lane shown on bit 2
    localparam int NUM_LANES = 2;
endpackage

// File: rtl/ep_susp_timer.sv
// Counts clock cycles spent in suspension up to LAT and flags when done.
// Assumes LAT >= 1. The count freezes in program-in-suspend and clears
// only when the state leaves both suspension codes.
module ep_susp_timer #(
    parameter int LAT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_susp,
    input  logic counting,
    output logic done
);
    localparam int CW = $clog2(LAT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LAT);

    logic [CW-1:0] cnt_q;

    // advance the latency count while suspended and not yet at the limit
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!in_susp)
            cnt_q <= '0;
        else if (counting && cnt_q != LIMIT)
            cnt_q <= cnt_q + 1'b1;
    end

    // settled once the limit is reached inside suspension
    always_comb done = in_susp && (cnt_q == LIMIT);
endmodule

// File: rtl/ep_toggle_bank.sv
// A bank of toggle flops, each flipping once per read strobe when enabled.
// Assumes rd is a single-cycle pulse per completed read.
module ep_toggle_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd,
    input  logic [N-1:0] en,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        logic t_q;
        // flip this lane on an enabled read strobe
        always_ff @(posedge clk) begin
            if (!rst_n)
                t_q <= 1'b0;
            else if (rd && en[i])
                t_q <= ~t_q;
        end
        assign q[i] = t_q;
    end
endmodule

// File: rtl/ep_view_mux.sv
// Chooses between the status byte and array data, and decides which
// toggle lanes may flip on the next read. Purely combinational.
module ep_view_mux
    import erase_poll_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [2:0]        state,
    input  logic              settled,
    input  logic              blk,
    input  logic              err,
    input  logic [DATA_W-1:0] arr,
    input  logic [NUM_LANES-1:0] tog,
    output logic [DATA_W-1:0] dout,
    output logic [NUM_LANES-1:0] en
);
    logic [STAT_W-1:0] stat;
    logic              use_stat;
    logic              pri, sec;

    assign pri = tog[LANE_PRI];
    assign sec = tog[LANE_SEC];

    // build the status byte and lane enables for the current view
    always_comb begin
        stat     = '0;
        use_stat = 1'b0;
        en       = '0;
        case (state)
            CS_TIMEOUT: begin
                use_stat     = 1'b1;
                stat         = {1'b0, pri, err, 1'b0, 1'b0, sec, 2'b00};
                en[LANE_PRI] = 1'b1;
                en[LANE_SEC] = blk;
            end
            CS_ERASE: begin
                use_stat     = 1'b1;
                stat         = {1'b0, pri, err, 1'b0, 1'b1, sec, 2'b00};
                en[LANE_PRI] = 1'b1;
                en[LANE_SEC] = blk;
            end
            CS_SUSPEND: begin
                if (!settled) begin
                    use_stat     = 1'b1;
                    stat         = {1'b0, pri, err, 1'b0, 1'b1, sec, 2'b00};
                    en[LANE_PRI] = 1'b1;
                    en[LANE_SEC] = blk;
                end else if (blk) begin
                    use_stat     = 1'b1;
                    stat         = {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, sec, 2'b00};
                    en[LANE_SEC] = 1'b1;
                end
            end
            CS_PGM_SUSP: begin
                use_stat = 1'b1;
                stat     = {1'b0, pri, err, 1'b0, 1'b0, sec, 2'b00};
                en       = '1;
            end
            default: use_stat = 1'b0;
        endcase
    end

    // widen the status byte to the data bus, upper bits zero
    always_comb begin
        if (use_stat)
            dout = DATA_W'(stat);
        else
            dout = arr;
    end
endmodule

// File: rtl/erase_poll_status.sv
// Top of the erase status polling generator: ties the suspend latency
// timer, the toggle bank and the view selector together.
// Assumes DATA_W >= 8 and a one-cycle rd_strobe per completed host read.
module erase_poll_status
    import erase_poll_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SUSP_LAT = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        ctrl_state,
    input  logic              blk_in_erase,
    input  logic              rd_strobe,
    input  logic              err_in,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              susp_settled
);
    logic                 in_susp;
    logic                 counting;
    logic [NUM_LANES-1:0] tog_q;
    logic [NUM_LANES-1:0] tog_en;

    // suspension covers both the plain and program-in-suspend codes
    always_comb begin
        in_susp  = (ctrl_state == CS_SUSPEND) || (ctrl_state == CS_PGM_SUSP);
        counting = (ctrl_state == CS_SUSPEND);
    end

    ep_susp_timer #(.LAT(SUSP_LAT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_susp  (in_susp),
        .counting (counting),
        .done     (susp_settled)
    );

    ep_toggle_bank #(.N(NUM_LANES)) u_tog (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (rd_strobe),
        .en    (tog_en),
        .q     (tog_q)
    );

    ep_view_mux #(.DATA_W(DATA_W)) u_view (
        .state   (ctrl_state),
        .settled (susp_settled),
        .blk     (blk_in_erase),
        .err     (err_in),
        .arr     (array_data),
        .tog     (tog_q),
        .dout    (rd_data),
        .en      (tog_en)
    );
endmodule

// File: rtl/erase_poll_status_chk.sv
// Property checker for erase_poll_status, attached by bind below.
// Observes ports and the toggle bank state.
module erase_poll_status_chk
    import erase_poll_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        ctrl_state,
    input logic              blk_in_erase,
    input logic              rd_strobe,
    input logic              err_in,
    input logic [DATA_W-1:0] array_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              susp_settled,
    input logic [1:0]        tog_q
);
    a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_state == CS_READ |-> rd_data == array_data);

    a_r3_timer_open: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_state == CS_TIMEOUT |-> !rd_data[3]);

    a_r3_timer_done: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_state == CS_ERASE |-> rd_data[3]);

    a_r4_err_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state == CS_ERASE || ctrl_state == CS_PGM_SUSP)
        |-> (rd_data[5] == err_in) && !rd_data[7]);

    a_r5_hold_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(tog_q));

    a_r5_flip_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && ctrl_state == CS_ERASE) |=> tog_q[0] != $past(tog_q[0]));

    a_r6_sec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state == CS_ERASE && !blk_in_erase) |=> tog_q[1] == $past(tog_q[1]));

    a_r7_rise_in_susp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(susp_settled) |-> $past(ctrl_state) == CS_SUSPEND);

    a_r8_pri_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state == CS_SUSPEND && susp_settled && blk_in_erase) |-> rd_data[6]);

    a_r10_both_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && ctrl_state == CS_PGM_SUSP) |=> (tog_q == ~$past(tog_q)));
endmodule

bind erase_poll_status erase_poll_status_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_state   (ctrl_state),
    .blk_in_erase (blk_in_erase),
    .rd_strobe    (rd_strobe),
    .err_in       (err_in),
    .array_data   (array_data),
    .rd_data      (rd_data),
    .susp_settled (susp_settled),
    .tog_q        (tog_q)
);

// File: tb/erase_poll_status_tb.sv
module erase_poll_status_tb;
    localparam int DATA_W   = 8;
    localparam int SUSP_LAT = 100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        st = 3'd0;
    logic              blk = 1'b0;
    logic              rd = 1'b0;
    logic              err = 1'b0;
    logic [DATA_W-1:0] arr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              settled;

    int checks = 0;
    int errors = 0;
    bit m_pri = 0, m_sec = 0;
    int m_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    erase_poll_status #(.DATA_W(DATA_W), .SUSP_LAT(SUSP_LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_state(st), .blk_in_erase(blk),
        .rd_strobe(rd), .err_in(err), .array_data(arr),
        .rd_data(rd_data), .susp_settled(settled)
    );

    function automatic bit m_settled(int c, logic [2:0] s);
        return (s == 3'd3 || s == 3'd4) && c == SUSP_LAT;
    endfunction

    // expected byte from the requirement tables
    function automatic logic [DATA_W-1:0] exp_byte(logic [2:0] s, bit stl, bit b,
            bit e, logic [DATA_W-1:0] a, bit p, bit q);
        case (s)
            3'd1: return {1'b0, p, e, 1'b0, 1'b0, q, 2'b00};
            3'd2: return {1'b0, p, e, 1'b0, 1'b1, q, 2'b00};
            3'd3: if (!stl) return {1'b0, p, e, 1'b0, 1'b1, q, 2'b00};
                  else if (b) return {5'b01000, q, 2'b00};
                  else return a;
            3'd4: return {1'b0, p, e, 1'b0, 1'b0, q, 2'b00};
            default: return a;
        endcase
    endfunction

    // which lanes the requirements let flip on a read: {sec, pri}
    function automatic logic [1:0] exp_en(logic [2:0] s, bit stl, bit b);
        case (s)
            3'd1, 3'd2: return {b, 1'b1};
            3'd3: if (!stl) return {b, 1'b1}; else return {b, 1'b0};
            3'd4: return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    // reference model of toggles and suspend count
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pri = 0; m_sec = 0; m_cnt = 0;
        end else begin
            logic [1:0] en;
            en = exp_en(st, m_settled(m_cnt, st), blk);
            if (rd && en[0]) m_pri = ~m_pri;
            if (rd && en[1]) m_sec = ~m_sec;
            if (st != 3'd3 && st != 3'd4) m_cnt = 0;
            else if (st == 3'd3 && m_cnt < SUSP_LAT) m_cnt++;
        end
    end

    task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_view(string tag);
        #1;
        chk(tag, rd_data, exp_byte(st, m_settled(m_cnt, st), blk, err, arr, m_pri, m_sec));
        chk({tag, " settled"}, {7'd0, settled}, {7'd0, m_settled(m_cnt, st)});
    endtask

    // one read: check the byte shown, then pulse the strobe over one edge
    task automatic do_read(string tag);
        @(negedge clk);
        rd = 1'b1;
        chk_view(tag);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        arr = 8'hA5;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk_view("R1 reset view / R2 passthru");

        // R2: reads in read-array state flip nothing
        do_read("R2 read array"); do_read("R2 read array");
        st = 3'd2; blk = 1'b1;
        @(negedge clk); #1;
        chk("R1 first status pri=0", {7'd0, rd_data[6]}, 8'd0);
        chk("R3 erasing timer=1", {7'd0, rd_data[3]}, 8'd1);
        do_read("R5 erase read"); do_read("R5 erase read");
        idle(17);
        chk_view("R5 hold without strobe");
        st = 3'd1; err = 1'b1;
        do_read("R3 R4 timeout read");
        blk = 1'b0;
        do_read("R6 blk=0 read"); do_read("R6 blk=0 read");
        err = 1'b0; st = 3'd2; blk = 1'b1;

        // R7: measure the suspend drain latency
        @(negedge clk);
        st = 3'd3;
        begin
            int n = 0;
            #1;
            chk("R7 drain shows erase view", {7'd0, rd_data[3]}, 8'd1);
            while (!settled && n < 5000) begin
                @(posedge clk); @(negedge clk); #1; n++;
            end
            chk("R7 latency cycles", 8'(n == SUSP_LAT), 8'd1);
            chk("R7 latency inside 25..3750", 8'(n >= 25 && n <= 3750), 8'd1);
        end
        do_read("R8 settled erasing block"); do_read("R8 settled erasing block");
        blk = 1'b0; arr = 8'h3C;
        do_read("R9 settled other block"); do_read("R9 settled other block");
        st = 3'd4; err = 1'b1;
        do_read("R10 program in suspend"); do_read("R10 program in suspend");
        st = 3'd3; blk = 1'b1;
        do_read("R7 R8 back to suspend, no restart");
        st = 3'd0;
        do_read("R2 back to read array");

        // constrained random phase
        for (int i = 0; i < 1500; i++) begin
            int r = $urandom_range(0, 9);
            st  = (r < 7) ? 3'(r % 5) : 3'd3;
            if ($urandom_range(0, 19) == 0) st = 3'($urandom_range(5, 7));
            blk = 1'($urandom_range(0, 1));
            err = 1'($urandom_range(0, 1));
            arr = 8'($urandom);
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 60));
            do_read("R5 R6 R7 R8 R9 R10 random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule